// File: doc/BRIEF.md
# Receive Pause Request Handshake Controller

This block turns received Ethernet flow-control pause events into a per-channel request and acknowledge handshake toward the user logic. There are nine independent channels. Bit 8 is the global (whole-link) pause channel and bits 7 to 0 are the eight priority pause channels. An upstream frame parser delivers a one-cycle strobe on the channel that a pause frame addressed, together with the 16-bit quanta value it carried. A separate quanta tick marks each elapsed pause quantum, which is 512 bit times of the link.

For each channel, a pause raises a request bit and loads a countdown timer. When the acknowledge-check mode is on, the channel holds the request and waits for the user's acknowledge before it starts counting. When the timer runs out, the request drops. In acknowledge-check mode the channel then waits for the acknowledge to fall, but it gives up after a fixed 32-cycle window. A fresh pause that arrives while a channel is busy reloads the timer and the sequence carries on.

Top module: `pause_req_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `pause_req` is 0 after that edge and every channel returns to idle.
- R2: A strobe on `pause_rx[i]` while channel i is idle and `chan_en[i]` is 0 is discarded: `pause_req[i]` stays 0.
- R3: A strobe on `pause_rx[i]` with `chan_en[i]` at 1 makes `pause_req[i]` read 1 after the same clock edge and loads `pause_quanta` into that channel's timer. Bit 8 is the global channel and bits 7..0 are priority channels 7..0.
- R4: With `ack_check_mode` at 1, a raised channel does not count quanta ticks until `chan_ack[i]` is sampled at 1.
- R5: With `ack_check_mode` at 0, counting starts on the edge after the request is raised, and no acknowledge is needed.
- R6: While counting, each `quanta_tick` decrements the timer. `pause_req[i]` falls at the edge that samples the N-th tick, where N is the loaded quanta (a quanta of 0 or 1 falls on the first tick). With `ack_check_mode` at 0 the channel is then idle.
- R7: With `ack_check_mode` at 1, after the request falls the channel stays in release-wait until `chan_ack[i]` is sampled at 0, and then it is idle.
- R8: If `chan_ack[i]` stays 1, release-wait ends by itself. A strobe sampled on the 32nd edge after the request fell is still treated as mid-sequence. From the 33rd edge on, the channel is idle.
- R9: A strobe on an active channel (waiting for acknowledge, counting, or in release-wait) reloads the timer with the new quanta whatever `chan_en[i]` is. From release-wait it raises `pause_req[i]` again and re-enters the acknowledge wait or the count, according to `ack_check_mode`.
- R10: Clearing `chan_en[i]` while channel i is active does not abort the sequence. The channel completes normally and then goes idle.
- R11: The channels are independent. Events on one channel do not change another channel's request or timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 9 | Per-channel pause accept enable |
| chan_ack | input | 9 | Per-channel user acknowledge |
| ack_check_mode | input | 1 | 1: wait for acknowledge before counting and for its release after |
| pause_rx | input | 9 | Per-channel one-cycle pause-received strobe |
| pause_quanta | input | 16 | Quanta value that accompanies a strobe |
| quanta_tick | input | 1 | One pulse per elapsed pause quantum |
| pause_req | output | 9 | Per-channel pause request toward the user |

## Verification
A channel that is stuck in the wrong state shows up at the request pins within a few cycles. If the count starts too early, the request falls on a tick that arrives before the acknowledge. If the timer is off by one, the fall moves by exactly one tick. Release-wait is not visible on the request pin by itself, so the bench exposes it by disabling the channel and sending a strobe: a channel still in release-wait raises the request on the next edge, while an idle one stays low. Probing the 32nd and the 33rd edge after the fall pins the release window to the exact cycle.

// File: rtl/pause_pkg.sv
// Package pause_pkg
// Shared types for the receive pause handshake channels.
// Assumes: a single clock domain; the encodings are internal only.
package pause_pkg;
    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_WAIT_ACK = 2'd1,
        CH_COUNT    = 2'd2,
        CH_WAIT_REL = 2'd3
    } ch_state_e;
endpackage

// File: rtl/pause_timer.sv
// Module pause_timer
// Loadable quanta down-counter. It reports "last" once its value is 1 or 0,
// so a loaded quanta N expires on the N-th tick (0 behaves like 1).
// Assumes: load has priority over dec; dec is only given while not last.
module pause_timer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [QW-1:0] cnt_q;

    // Count register: reload or step down by one quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q > QW'(1))
            cnt_q <= cnt_q - QW'(1);
    end

    // Expiry flag: the next tick ends the pause.
    assign last = (cnt_q <= QW'(1));
endmodule

// File: rtl/pause_release_timer.sv
// Module pause_release_timer
// Counts cycles spent in release-wait and flags the final one.
// Assumes: clr is given on the edge that enters release-wait.
module pause_release_timer #(
    parameter int REL_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int RW = (REL_CYCLES > 2) ? $clog2(REL_CYCLES) : 1;

    logic [RW-1:0] cnt_q;

    // Cycle counter for the release window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + RW'(1);
    end

    // Window end: this is the last cycle of release-wait.
    assign done = (cnt_q == RW'(REL_CYCLES - 1));
endmodule

// File: rtl/pause_chan.sv
// Module pause_chan
// One pause channel: request raise, optional acknowledge wait, quanta
// countdown, request drop and release handshake with a timeout.
// Assumes: rx is a one-cycle strobe with quanta valid in the same cycle.
module pause_chan
    import pause_pkg::*;
#(
    parameter int QW         = 16,
    parameter int REL_CYCLES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ack,
    input  logic          ack_mode,
    input  logic          rx,
    input  logic [QW-1:0] quanta,
    input  logic          tick,
    output logic          req
);
    ch_state_e state_q, state_d;
    logic      req_q, req_set, req_clr;
    logic      tmr_load, tmr_dec, tmr_last;
    logic      rel_clr, rel_run, rel_done;

    pause_timer #(.QW(QW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (quanta),
        .dec      (tmr_dec),
        .last     (tmr_last)
    );

    pause_release_timer #(.REL_CYCLES(REL_CYCLES)) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rel_clr),
        .run   (rel_run),
        .done  (rel_done)
    );

    // Next-state and control decode for the channel sequence.
    always_comb begin
        state_d  = state_q;
        req_set  = 1'b0;
        req_clr  = 1'b0;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        rel_clr  = 1'b0;
        rel_run  = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (rx && en) begin
                    tmr_load = 1'b1;
                    req_set  = 1'b1;
                    state_d  = ack_mode ? CH_WAIT_ACK : CH_COUNT;
                end
            end
            CH_WAIT_ACK: begin
                tmr_load = rx;
                if (!ack_mode || ack)
                    state_d = CH_COUNT;
            end
            CH_COUNT: begin
                if (rx) begin
                    tmr_load = 1'b1;
                end else if (tick) begin
                    if (tmr_last) begin
                        req_clr = 1'b1;
                        rel_clr = 1'b1;
                        state_d = ack_mode ? CH_WAIT_REL : CH_IDLE;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
            end
            CH_WAIT_REL: begin
                if (rx) begin
                    tmr_load = 1'b1;
                    req_set  = 1'b1;
                    state_d  = ack_mode ? CH_WAIT_ACK : CH_COUNT;
                end else if (!ack_mode || !ack || rel_done) begin
                    state_d = CH_IDLE;
                end else begin
                    rel_run = 1'b1;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= CH_IDLE;
        else
            state_q <= state_d;
    end

    // Request flag toward the user.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (req_set)
            req_q <= 1'b1;
        else if (req_clr)
            req_q <= 1'b0;
    end

    assign req = req_q;
endmodule

// File: rtl/pause_req_ctrl.sv
// Module pause_req_ctrl
// Top of the receive pause handshake: one pause_chan per channel, all
// sharing the quanta bus, the tick and the acknowledge-check mode.
// Assumes: the highest channel index is the global pause, the rest are
// priority channels; one quanta value is presented per cycle.
module pause_req_ctrl #(
    parameter int NUM_CH     = 9,
    parameter int QUANTA_W   = 16,
    parameter int REL_CYCLES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   chan_en,
    input  logic [NUM_CH-1:0]   chan_ack,
    input  logic                ack_check_mode,
    input  logic [NUM_CH-1:0]   pause_rx,
    input  logic [QUANTA_W-1:0] pause_quanta,
    input  logic                quanta_tick,
    output logic [NUM_CH-1:0]   pause_req
);
    // One independent sequence per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pause_chan #(
            .QW         (QUANTA_W),
            .REL_CYCLES (REL_CYCLES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (chan_en[g]),
            .ack      (chan_ack[g]),
            .ack_mode (ack_check_mode),
            .rx       (pause_rx[g]),
            .quanta   (pause_quanta),
            .tick     (quanta_tick),
            .req      (pause_req[g])
        );
    end
endmodule

// File: rtl/pause_req_ctrl_chk.sv
// Module pause_req_ctrl_chk
// Port-level properties of the pause handshake, bound to pause_req_ctrl.
// Assumes: same clock and reset as the top.
module pause_req_ctrl_chk #(
    parameter int NUM_CH = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] pause_rx,
    input logic              quanta_tick,
    input logic [NUM_CH-1:0] pause_req
);
    logic rst_seen_q;

    // Remember that reset was sampled on the previous edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Requests are clear after any reset edge.
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1)
            // R1
            reset_clear_chk: assert (pause_req == '0)
                else $error("reset_clear_chk");
    end

    // R3
    enabled_rx_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pause_rx & chan_en) != '0) |=> (($past(pause_rx & chan_en) & ~pause_req) == '0));

    // R3
    req_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pause_req & ~$past(pause_req) & ~$past(pause_rx)) == '0));

    // R9
    reload_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pause_rx & pause_req) != '0) |=> (($past(pause_rx & pause_req) & ~pause_req) == '0));

    // R6
    fall_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((~pause_req & $past(pause_req)) == '0) || $past(quanta_tick)));
endmodule

bind pause_req_ctrl pause_req_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .pause_rx    (pause_rx),
    .quanta_tick (quanta_tick),
    .pause_req   (pause_req)
);

// File: tb/tb_pause_req_ctrl.sv
// Scoreboard bench: driver tasks queue expected request vectors with the
// cycle they are due; a monitor pops and compares them at each falling edge.
module tb_pause_req_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 9;
    localparam int QW  = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] chan_en;
    logic [NCH-1:0] chan_ack;
    logic           ack_check_mode;
    logic [NCH-1:0] pause_rx;
    logic [QW-1:0]  pause_quanta;
    logic           quanta_tick;
    logic [NCH-1:0] pause_req;

    typedef struct {
        int             due;
        logic [NCH-1:0] val;
        string          tag;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 1'b0;

    pause_req_ctrl dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .chan_en        (chan_en),
        .chan_ack       (chan_ack),
        .ack_check_mode (ack_check_mode),
        .pause_rx       (pause_rx),
        .pause_quanta   (pause_quanta),
        .quanta_tick    (quanta_tick),
        .pause_req      (pause_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due at this falling edge.
    always @(negedge clk) begin : mon
        exp_t e;
        while (expq.size() > 0 && expq[0].due <= cyc) begin
            e = expq.pop_front();
            checks++;
            if (e.due != cyc || pause_req !== e.val) begin
                fails++;
                $display("FAIL %s: pause_req=%h expected=%h (cycle %0d, due %0d)",
                         e.tag, pause_req, e.val, cyc, e.due);
            end
        end
    end

    task automatic nxt();
        @(negedge clk);
    endtask

    // Queue the value expected after the next rising edge.
    task automatic expect_next(logic [NCH-1:0] v, string tag);
        exp_t e;
        e.due = cyc + 1;
        e.val = v;
        e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic pulse_rx(logic [NCH-1:0] m, logic [QW-1:0] q,
                            logic [NCH-1:0] ev, string tag);
        pause_rx     = m;
        pause_quanta = q;
        expect_next(ev, tag);
        nxt();
        pause_rx = '0;
    endtask

    task automatic do_tick(logic [NCH-1:0] ev, string tag);
        quanta_tick = 1'b1;
        expect_next(ev, tag);
        nxt();
        quanta_tick = 1'b0;
    endtask

    task automatic idle_cyc(int n, logic [NCH-1:0] ev, string tag);
        for (int k = 0; k < n; k++) begin
            expect_next(ev, tag);
            nxt();
        end
    endtask

    // Probe the release window: gap edges after the fall, on a disabled channel.
    task automatic release_probe(int ch, int gap, bit accept);
        logic [NCH-1:0] m;
        m = NCH'(1) << ch;
        ack_check_mode = 1'b1;
        chan_ack = m;
        pulse_rx(m, 16'd0, m, "R3 raise for release probe");
        idle_cyc(1, m, "R4 acknowledge already high");
        do_tick('0, "R6 zero quanta ends on first tick");
        chan_en = ~m;
        idle_cyc(gap - 1, '0, "R8 release-wait request low");
        pulse_rx(m, 16'd2, accept ? m : '0,
                 accept ? "R8 edge 32 still in release-wait" : "R8 edge 33 idle, disabled ignored");
        if (accept) begin
            idle_cyc(1, m, "R9 re-raised from release-wait");
            do_tick(m, "R9 reloaded quanta tick 1");
            do_tick('0, "R9 reloaded quanta tick 2");
        end
        chan_ack = '0;
        chan_en  = '1;
        idle_cyc(1, '0, "R7 release complete");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n          = 1'b0;
        chan_en        = '1;
        chan_ack       = '0;
        ack_check_mode = 1'b0;
        pause_rx       = '0;
        pause_quanta   = '0;
        quanta_tick    = 1'b0;
        nxt();
        nxt();
        expect_next('0, "R1 reset clears requests");
        nxt();
        rst_n = 1'b1;
        idle_cyc(1, '0, "R1 idle after reset");

        // R2: disabled idle channel discards the pause.
        chan_en = 9'h1F7;
        pulse_rx(9'h008, 16'd5, '0, "R2 disabled channel ignored");
        idle_cyc(2, '0, "R2 stays idle");
        chan_en = '1;

        // R3, R5, R6: global channel, no acknowledge mode, quanta 3.
        ack_check_mode = 1'b0;
        pulse_rx(9'h100, 16'd3, 9'h100, "R3 global request raised");
        idle_cyc(2, 9'h100, "R5 no tick no expiry");
        do_tick(9'h100, "R5 counting tick 1");
        do_tick(9'h100, "R6 tick 2");
        do_tick('0, "R6 expiry on tick 3");
        chan_en = 9'h0FF;
        pulse_rx(9'h100, 16'd1, '0, "R6 idle after expiry in mode 0");
        chan_en = '1;

        // R4, R7: acknowledge mode on priority 0.
        ack_check_mode = 1'b1;
        pulse_rx(9'h001, 16'd1, 9'h001, "R3 priority 0 raised");
        do_tick(9'h001, "R4 held without acknowledge");
        do_tick(9'h001, "R4 held without acknowledge");
        do_tick(9'h001, "R4 held without acknowledge");
        chan_ack = 9'h001;
        expect_next(9'h001, "R4 acknowledge seen");
        nxt();
        do_tick('0, "R6 quanta 1 ends on first tick");
        idle_cyc(3, '0, "R7 release-wait");
        chan_ack = '0;
        expect_next('0, "R7 acknowledge dropped");
        nxt();
        chan_en = 9'h1FE;
        pulse_rx(9'h001, 16'd2, '0, "R7 idle after release");
        chan_en = '1;

        // R8: release timeout boundary.
        release_probe(1, 33, 1'b0);
        release_probe(2, 32, 1'b1);

        // R9: reload while counting.
        ack_check_mode = 1'b0;
        pulse_rx(9'h020, 16'd2, 9'h020, "R3 priority 5 raised");
        do_tick(9'h020, "R6 first tick of 2");
        pulse_rx(9'h020, 16'd4, 9'h020, "R9 reload mid count");
        do_tick(9'h020, "R9 new quanta tick 1");
        do_tick(9'h020, "R9 new quanta tick 2");
        do_tick(9'h020, "R9 new quanta tick 3");
        do_tick('0, "R9 expiry after new quanta");

        // R10, R11: two channels, disabled mid sequence.
        pulse_rx(9'h0C0, 16'd2, 9'h0C0, "R11 two channels raised");
        chan_en = 9'h13F;
        do_tick(9'h0C0, "R10 disable does not abort");
        pulse_rx(9'h080, 16'd3, 9'h0C0, "R9 reload while disabled");
        do_tick(9'h080, "R11 channel 6 expires alone");
        do_tick(9'h080, "R11 channel 7 still counting");
        do_tick('0, "R10 completes after disable");
        chan_en = '1;
        idle_cyc(2, '0, "R11 all idle");

        nxt();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule